// File: doc/BRIEF.md
# Byte-Lane Register Access Adapter

This adapter sits on the slave side of a bus, in front of a bank of 16-bit registers. Each register occupies one even byte address. A register's upper half (bits 15:8) is called byte 0, and its lower half (bits 7:0) is called byte 1. A requester sends a size code, a byte address and, for writes, a halfword of data. The adapter turns each request into a register index, per-byte write enables and write data for the bank, and it returns the read data together with a one-cycle acknowledge.

Byte accesses and even-address halfword accesses finish in one bank cycle. A halfword access at an odd address touches two registers. The adapter splits it into two back-to-back byte cycles: first the low byte of location N, then the high byte of location N+1. It holds off new requests through its ready output until the pair is done, and it acknowledges only once. The location index wraps, so an odd halfword at the top location continues at location 0.

The bank reads combinationally: `reg_rdata` must show the contents of `reg_idx` in the same cycle. Bank writes take effect at the clock edge when `reg_wr` is high.

Top module: `bytelane_adapter`

## Requirements
- R1: After reset the adapter is idle. `req_ready` is 1, `resp_ack` is 0, `reg_wr` is 0, and no byte enable is active. While idle with no request, it drives no enables.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. Size code 2'b10 means a halfword. Every other size code means a byte access. `req_addr[0]` selects the even byte (0) or the odd byte (1). `req_addr[IDX_W:1]` is the location index.
- R3: A byte write to an even address writes `req_wdata[15:8]` into byte 0 (bits 15:8) of the location. Byte 1 is left unchanged.
- R4: A byte write to an odd address writes `req_wdata[7:0]` into byte 1 (bits 7:0) of the location. Byte 0 is left unchanged.
- R5: Every byte read returns all 16 bits of the addressed location on `resp_rdata`.
- R6: A halfword access at an even address reads or writes all 16 bits of one location. `resp_ack` is high in the cycle right after acceptance.
- R7: A halfword write at an odd address N*2+1 takes two bank cycles. In the first, `req_wdata[15:8]` is written to byte 1 of location N. In the second, `req_wdata[7:0]` is written to byte 0 of location N+1.
- R8: A halfword read at an odd address returns {byte 1 of N, byte 0 of N+1}. A single `resp_ack` comes two cycles after acceptance, and `resp_ack` stays low in the cycle between.
- R9: During the second cycle of a split access, `req_ready` is 0, and the adapter accepts no new request.
- R10: A split access whose first cycle is at the highest location performs its second cycle at location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter can take a request |
| req_size | input | 2 | Size code: 2'b10 is a halfword, any other code is a byte |
| req_addr | input | IDX_W+1 | Byte address; bit 0 selects the byte |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 16 | Write halfword |
| resp_ack | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 16 | Read data, valid while resp_ack is high |
| reg_idx | output | IDX_W | Register location index |
| reg_be | output | 2 | Byte enables: bit 1 is byte 0 (15:8), bit 0 is byte 1 (7:0) |
| reg_wr | output | 1 | Write strobe to the bank |
| reg_wdata | output | 16 | Data to the bank |
| reg_rdata | input | 16 | Combinational read data of location reg_idx |

## Verification
The split sequencer is the only state in the block. If that state is stuck or wrong, the ports show it within one cycle after acceptance: `req_ready` fails to drop, the acknowledge arrives one cycle early or late, or the second write lands on the wrong location or lane. A wrong lane or a wrong held byte shows up only as register contents. The bench therefore reads each affected location back, and also reads its neighbour, to catch a lane that was corrupted or left untouched.

// File: rtl/bytelane_adapter.sv
module bytelane_adapter #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_size,
  input  logic [IDX_W:0]   req_addr,
  input  logic             req_write,
  input  logic [15:0]      req_wdata,
  output logic             resp_ack,
  output logic [15:0]      resp_rdata,
  output logic [IDX_W-1:0] reg_idx,
  output logic [1:0]       reg_be,
  output logic             reg_wr,
  output logic [15:0]      reg_wdata,
  input  logic [15:0]      reg_rdata
);
  localparam logic [1:0] SZ_HALF = 2'b10;

  logic             second_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       wlo_q;
  logic [7:0]       rhi_q;
  logic             wr_q;

  wire accept = req_valid & req_ready;
  wire half   = (req_size == SZ_HALF);
  wire odd    = req_addr[0];
  wire split  = half & odd;

  assign req_ready = ~second_q;

  always_comb begin
    reg_idx   = req_addr[IDX_W:1];
    reg_be    = 2'b00;
    reg_wr    = 1'b0;
    reg_wdata = req_wdata;
    if (second_q) begin
      reg_idx   = idx_q + 1'b1;
      reg_be    = 2'b10;
      reg_wr    = wr_q;
      reg_wdata = {wlo_q, wlo_q};
    end else if (accept) begin
      reg_wr = req_write;
      if (half && !odd)  reg_be = 2'b11;
      else if (odd)      reg_be = 2'b01;
      else               reg_be = 2'b10;
      if (split) reg_wdata = {req_wdata[15:8], req_wdata[15:8]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q   <= 1'b0;
      idx_q      <= '0;
      wlo_q      <= '0;
      rhi_q      <= '0;
      wr_q       <= 1'b0;
      resp_ack   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_ack <= 1'b0;
      if (second_q) begin
        second_q   <= 1'b0;
        resp_ack   <= 1'b1;
        resp_rdata <= {rhi_q, reg_rdata[15:8]};
      end else if (accept) begin
        if (split) begin
          second_q <= 1'b1;
          idx_q    <= req_addr[IDX_W:1];
          wlo_q    <= req_wdata[7:0];
          rhi_q    <= reg_rdata[7:0];
          wr_q     <= req_write;
        end else begin
          resp_ack   <= 1'b1;
          resp_rdata <= reg_rdata;
        end
      end
    end
  end
endmodule

// File: rtl/bytelane_adapter_chk.sv
module bytelane_adapter_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_size,
  input logic [IDX_W:0]   req_addr,
  input logic             resp_ack,
  input logic [IDX_W-1:0] reg_idx,
  input logic [1:0]       reg_be,
  input logic             reg_wr
);
  wire acc   = req_valid && req_ready;
  wire splt  = acc && req_size == 2'b10 && req_addr[0];
  wire [IDX_W-1:0] nxt = IDX_W'(req_addr[IDX_W:1] + 1'b1);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |-> (reg_be == 2'b00 && !reg_wr));

  p_aligned_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !splt) |=> resp_ack);

  p_second_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    splt |=> (reg_be == 2'b10 && reg_idx == $past(nxt)));

  p_split_no_early_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    splt |=> !resp_ack);

  p_split_late_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    splt |=> ##1 resp_ack);

  p_busy_during_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
    splt |=> !req_ready);
endmodule

bind bytelane_adapter bytelane_adapter_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_size(req_size), .req_addr(req_addr), .resp_ack(resp_ack),
  .reg_idx(reg_idx), .reg_be(reg_be), .reg_wr(reg_wr)
);

// File: tb/bytelane_adapter_test.sv
module bytelane_adapter_test;
  localparam int IDX_W = 3;
  localparam int NLOC  = 1 << IDX_W;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [1:0] req_size = 0;
  logic [IDX_W:0] req_addr = 0;
  logic req_write = 0;
  logic [15:0] req_wdata = 0;
  logic resp_ack;
  logic [15:0] resp_rdata;
  logic [IDX_W-1:0] reg_idx;
  logic [1:0] reg_be;
  logic reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [15:0] mem [NLOC];

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  bytelane_adapter #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_addr(req_addr), .req_write(req_write),
    .req_wdata(req_wdata), .resp_ack(resp_ack), .resp_rdata(resp_rdata),
    .reg_idx(reg_idx), .reg_be(reg_be), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_idx];
  always @(posedge clk) if (reg_wr) begin
    if (reg_be[1]) mem[reg_idx][15:8] <= reg_wdata[15:8];
    if (reg_be[0]) mem[reg_idx][7:0]  <= reg_wdata[7:0];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] sz, input logic [IDX_W:0] a, input logic wr,
                        input logic [15:0] wd, output logic [15:0] rd, output int lat);
    @(negedge clk);
    req_size = sz; req_addr = a; req_write = wr; req_wdata = wd; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    if (!resp_ack && sz == 2'b10 && a[0]) chk("R9 busy in second cycle", {31'd0, req_ready}, 0);
    while (!resp_ack && lat < 10) begin @(negedge clk); lat++; end
    rd = resp_rdata;
  endtask

  task automatic wr16(input logic [IDX_W:0] a, input logic [15:0] d);
    logic [15:0] r; int l;
    access(2'b10, a, 1, d, r, l);
  endtask

  task automatic rd16(input logic [IDX_W:0] a, output logic [15:0] d);
    int l;
    access(2'b10, a, 0, 0, d, l);
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", {31'd0, req_ready}, 1);
    chk("R1 ack after reset", {31'd0, resp_ack}, 0);
    chk("R1 enables idle", {29'd0, reg_wr, reg_be}, 0);
  endtask

  task automatic t_aligned();
    logic [15:0] r; int l;
    access(2'b10, 4'd4, 1, 16'h1234, r, l);
    chk("R6 aligned write latency", l, 1);
    access(2'b10, 4'd4, 0, 0, r, l);
    chk("R6 aligned read data", r, 16'h1234);
    chk("R6 aligned read latency", l, 1);
  endtask

  task automatic t_byte_even();
    logic [15:0] r; int l;
    access(2'b01, 4'd4, 1, 16'hAB00, r, l);
    access(2'b01, 4'd4, 0, 0, r, l);
    chk("R3 R5 byte even write, full read", r, 16'hAB34);
  endtask

  task automatic t_byte_odd();
    logic [15:0] r; int l;
    access(2'b01, 4'd5, 1, 16'hFFCD, r, l);
    access(2'b01, 4'd5, 0, 0, r, l);
    chk("R4 R5 byte odd write, full read", r, 16'hABCD);
  endtask

  task automatic t_other_size();
    logic [15:0] r; int l;
    access(2'b00, 4'd4, 1, 16'h5566, r, l);
    chk("R2 size 00 latency", l, 1);
    rd16(4'd4, r);
    chk("R2 size 00 acts as byte", r, 16'h55CD);
    access(2'b11, 4'd5, 1, 16'h7788, r, l);
    rd16(4'd4, r);
    chk("R2 size 11 acts as byte", r, 16'h5588);
  endtask

  task automatic t_split();
    logic [15:0] r; int l;
    wr16(4'd6, 16'h1111);
    wr16(4'd8, 16'h2222);
    wr16(4'd10, 16'h3333);
    access(2'b10, 4'd7, 1, 16'hA5C3, r, l);
    chk("R7 split write latency", l, 2);
    rd16(4'd6, r);
    chk("R7 first location lane", r, 16'h11A5);
    rd16(4'd8, r);
    chk("R7 second location lane", r, 16'hC322);
    rd16(4'd10, r);
    chk("R7 neighbour untouched", r, 16'h3333);
    access(2'b10, 4'd7, 0, 0, r, l);
    chk("R8 split read data", r, 16'hA5C3);
    chk("R8 split read latency", l, 2);
  endtask

  task automatic t_wrap();
    logic [15:0] r; int l;
    wr16(4'd14, 16'h7777);
    wr16(4'd0, 16'h0000);
    wr16(4'd2, 16'h4444);
    access(2'b10, 4'd15, 1, 16'h9ABC, r, l);
    rd16(4'd14, r);
    chk("R10 top location low byte", r, 16'h779A);
    rd16(4'd0, r);
    chk("R10 wrapped to location 0", r, 16'hBC00);
    rd16(4'd2, r);
    chk("R10 location 1 untouched", r, 16'h4444);
    access(2'b10, 4'd15, 0, 0, r, l);
    chk("R10 wrapped read", r, 16'h9ABC);
  endtask

  initial begin
    for (int i = 0; i < NLOC; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_byte_even();
    t_byte_odd();
    t_other_size();
    t_split();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule